// File: doc/BRIEF.md
# Load/Store Alignment Unit

This unit sits between the data port of a 32-bit integer core and a word-addressed data memory that has one write-enable per byte. In the cycle of a request it adds the base register to the sign-extended immediate to form the byte address. It sends the word address to memory. For a write, it moves the register data onto the correct byte lanes and sets the matching byte mask. Half-word and word accesses that do not sit on their natural boundary never reach memory: the unit raises a flag for them instead.

Memory returns read data one cycle after an accepted read. The unit keeps the width, the signedness and the byte offset of that read for one cycle. In the next cycle it takes the addressed field out of the returned word and widens it to 32 bits with zeros or with copies of its top bit. All width and signedness choices come from the 3-bit width code of the instruction.

Top module: `lsu_align_unit`

## Requirements
- R1: The byte address is base_i + imm_i, modulo 2^32. During an accepted request, mem_addr_o equals bits [31:2] of that address.
- R2: Width code bits [1:0] select the size: 00 byte, 01 half-word, 10 or 11 word. Bit 2 set selects zero extension for byte and half-word reads and has no effect on word accesses.
- R3: For an accepted byte write, mem_wdata_o holds store_data_i[7:0] in all four lanes, and mem_be_o is 4'b0001 shifted left by address bits [1:0].
- R4: For an accepted half-word write, mem_wdata_o holds store_data_i[15:0] in both halves, and mem_be_o is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R5: For an accepted word write, mem_wdata_o equals store_data_i and mem_be_o is 4'b1111.
- R6: A half-word request with address bit 0 set, or a word request with address bits [1:0] not 00, drives misaligned_o high, mem_req_o low, mem_we_o low and mem_be_o to 0000. Such a read produces no load_valid_o in the next cycle.
- R7: load_valid_o is high in exactly the cycle after an accepted read (mem_req_o high, mem_we_o low) and low in every other cycle. In that cycle, load_data_o is formed from mem_rdata_i.
- R8: A byte read returns the lane selected by address bits [1:0] in bits [7:0]. Bits [31:8] are copies of bit 7 when code bit 2 is 0, and zero when it is 1.
- R9: A half-word read returns the half selected by address bit 1 in bits [15:0]. Bits [31:16] are copies of bit 15 when code bit 2 is 0, and zero when it is 1.
- R10: A word read returns mem_rdata_i unchanged.
- R11: With req_i low, mem_req_o, mem_we_o, mem_be_o and misaligned_o are all zero. load_data_o is zero whenever load_valid_o is low.
- R12: While rst_ni is low and in the first cycle after it, load_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request from the core this cycle |
| we_i | input | 1 | 1 for a store, 0 for a load |
| funct3_i | input | 3 | Width/sign code |
| base_i | input | 32 | Base register value |
| imm_i | input | 32 | Sign-extended immediate offset |
| store_data_i | input | 32 | Register data to store |
| mem_req_o | output | 1 | Accepted request to memory |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 30 | Word address |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_be_o | output | 4 | Byte write mask |
| misaligned_o | output | 1 | Request rejected for misalignment |
| mem_rdata_i | input | 32 | Read word, valid one cycle after an accepted read |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The checks assume that mem_rdata_i is meaningful only in the cycle after an accepted read, and that req_i, we_i and funct3_i are driven to known values every cycle. They also assume that memory accepts every request in a single cycle without stalling. The bench keeps to these assumptions with a one-cycle registered memory model that answers every accepted read. It drives all inputs from one task shortly after each rising edge. The stimulus covers every width code, including the redundant word codes, and random full-range bases and offsets, so every lane and every misaligned offset is exercised.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  function automatic size_e decode_size(input logic [2:0] code);
    if (code[1]) return SZ_WORD;
    if (code[0]) return SZ_HALF;
    return SZ_BYTE;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(NUM_LANES)
) (
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-1:0]       imm_i,
  input  size_e                   size_i,
  output logic [ADDR_W-OFF_W-1:0] word_addr_o,
  output logic [OFF_W-1:0]        offset_o,
  output logic                    misaligned_o
);
  logic [ADDR_W-1:0] ea;

  assign ea          = base_i + imm_i;
  assign word_addr_o = ea[ADDR_W-1:OFF_W];
  assign offset_o    = ea[OFF_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_HALF: misaligned_o = ea[0];
      SZ_WORD: misaligned_o = |ea[OFF_W-1:0];
      default: misaligned_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(NUM_LANES)
) (
  input  logic                 en_i,
  input  size_e                size_i,
  input  logic [OFF_W-1:0]     offset_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_LANES-1:0] be_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_m;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          lane_d = data_i[7:0];
          lane_m = (offset_i == OFF_W'(g));
        end
        SZ_HALF: begin
          lane_d = data_i[8*(g%2) +: 8];
          lane_m = (offset_i[OFF_W-1:1] == (OFF_W-1)'(g/2));
        end
        default: begin
          lane_d = data_i[8*g +: 8];
          lane_m = 1'b1;
        end
      endcase
    end
    assign wdata_o[8*g +: 8] = lane_d;
    assign be_o[g]           = en_i & lane_m;
  end

  always_comb begin
    if (en_i && size_i == SZ_BYTE)
      a_r3_byte_mask_single: assert ($countones(be_o) == 1);
    if (en_i && size_i == SZ_HALF)
      a_r4_half_mask_pair: assert ($countones(be_o) == 2 && (be_o & (be_o >> 1)) != '0);
    if (!en_i)
      a_r11_mask_quiet: assert (be_o == '0);
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(NUM_LANES)
) (
  input  logic              valid_i,
  input  size_e             size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]  byte_lane [NUM_LANES];
  logic [15:0] half_lane [NUM_LANES/2];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_byte
    assign byte_lane[g] = rdata_i[8*g +: 8];
  end
  for (genvar g = 0; g < NUM_LANES/2; g++) begin : g_half
    assign half_lane[g] = rdata_i[16*g +: 16];
  end

  assign sel_b = byte_lane[offset_i];
  assign sel_h = half_lane[offset_i[OFF_W-1:1]];

  always_comb begin
    data_o = '0;
    if (valid_i) begin
      unique case (size_i)
        SZ_BYTE: data_o = {{(DATA_W-8){sel_b[7] & ~unsigned_i}}, sel_b};
        SZ_HALF: data_o = {{(DATA_W-16){sel_h[15] & ~unsigned_i}}, sel_h};
        default: data_o = rdata_i;
      endcase
    end
  end

  always_comb begin
    if (valid_i && size_i == SZ_BYTE && unsigned_i)
      a_r8_zero_fill: assert (data_o[DATA_W-1:8] == '0);
    if (valid_i && size_i == SZ_HALF && !unsigned_i)
      a_r9_sign_fill: assert (data_o[DATA_W-1:16] == {(DATA_W-16){rdata_i[16*offset_i[OFF_W-1]+15]}});
    if (!valid_i)
      a_r11_idle_zero: assert (data_o == '0);
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(NUM_LANES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [2:0]              funct3_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-1:0]       imm_i,
  input  logic [DATA_W-1:0]       store_data_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-OFF_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic [NUM_LANES-1:0]    mem_be_o,
  output logic                    misaligned_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    load_valid_o,
  output logic [DATA_W-1:0]       load_data_o
);
  size_e            req_size;
  logic [OFF_W-1:0] req_off;
  logic             req_mis;
  logic             accept;

  size_e            ctx_size_q;
  logic [OFF_W-1:0] ctx_off_q;
  logic             ctx_uns_q;
  logic             ctx_valid_q;

  assign req_size = decode_size(funct3_i);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .base_i      (base_i),
    .imm_i       (imm_i),
    .size_i      (req_size),
    .word_addr_o (mem_addr_o),
    .offset_o    (req_off),
    .misaligned_o(req_mis)
  );

  assign accept       = req_i & ~req_mis;
  assign misaligned_o = req_i & req_mis;
  assign mem_req_o    = accept;
  assign mem_we_o     = accept & we_i;

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
    .en_i    (mem_we_o),
    .size_i  (req_size),
    .offset_i(req_off),
    .data_i  (store_data_i),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  // read context, held for the cycle the memory answers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_valid_q <= 1'b0;
      ctx_size_q  <= SZ_BYTE;
      ctx_off_q   <= '0;
      ctx_uns_q   <= 1'b0;
    end else begin
      ctx_valid_q <= accept & ~we_i;
      if (accept && !we_i) begin
        ctx_size_q <= req_size;
        ctx_off_q  <= req_off;
        ctx_uns_q  <= funct3_i[2];
      end
    end
  end

  assign load_valid_o = ctx_valid_q;

  lsu_load_extend #(.DATA_W(DATA_W)) u_load (
    .valid_i   (ctx_valid_q),
    .size_i    (ctx_size_q),
    .unsigned_i(ctx_uns_q),
    .offset_i  (ctx_off_q),
    .rdata_i   (mem_rdata_i),
    .data_o    (load_data_o)
  );

  a_r6_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0));

  a_r7_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o);

  a_r7_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !mem_we_o) |=> !load_valid_o);

  a_r11_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!mem_req_o && !misaligned_o && mem_be_o == '0));

  a_r5_word_mask_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i[1]) |-> (mem_be_o == '1));
endmodule

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  funct3_i = '0;
  logic [31:0] base_i = '0, imm_i = '0, store_data_i = '0;
  logic        mem_req_o, mem_we_o, misaligned_o, load_valid_o;
  logic [29:0] mem_addr_o;
  logic [31:0] mem_wdata_o, load_data_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  bit          pend_v = 0;
  logic [31:0] pend_d = '0;
  string       pend_tag = "R10";

  always #2.5 clk_i = ~clk_i;

  lsu_align_unit u0 (.*);

  // one-cycle memory, answers from the unit's outputs
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[3:0]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end else mem_rdata_i <= mem[mem_addr_o[3:0]];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(bit req, bit we, logic [2:0] f3, logic [31:0] base,
                      logic [31:0] imm, logic [31:0] sd);
    logic [31:0] ea, w, exp_wd, v;
    logic [3:0]  exp_be;
    int          sz, off;
    bit          mis, acc;
    string       t;
    req_i = req; we_i = we; funct3_i = f3; base_i = base; imm_i = imm; store_data_i = sd;
    #2;
    ea  = base + imm;
    off = int'(ea[1:0]);
    sz  = f3[1] ? 2 : (f3[0] ? 1 : 0);
    mis = req && ((sz == 1 && ea[0]) || (sz == 2 && off != 0));
    acc = req && !mis;
    chk("R6 misaligned_o", 32'(misaligned_o), 32'(mis));
    chk("R6 R11 mem_req_o", 32'(mem_req_o), 32'(acc));
    chk("R6 R11 mem_we_o", 32'(mem_we_o), 32'(acc && we));
    exp_be = '0; exp_wd = sd;
    if (acc && we) begin
      case (sz)
        0: begin exp_be = 4'b0001 << off; exp_wd = {4{sd[7:0]}}; end
        1: begin exp_be = ea[1] ? 4'b1100 : 4'b0011; exp_wd = {2{sd[15:0]}}; end
        default: exp_be = 4'b1111;
      endcase
      t = (sz == 0) ? "R3" : (sz == 1) ? "R4" : "R5";
      chk({t, " mem_wdata_o"}, mem_wdata_o, exp_wd);
    end else t = "R11";
    chk({t, " mem_be_o"}, 32'(mem_be_o), 32'(exp_be));
    if (acc) chk("R1 mem_addr_o", 32'(mem_addr_o), 32'(ea[31:2]));
    chk("R7 R12 load_valid_o", 32'(load_valid_o), 32'(pend_v));
    if (pend_v) chk(pend_tag, load_data_o, pend_d);
    else chk("R11 load_data_o", load_data_o, 32'h0);
    // expected read result for this request
    w = exp_mem[ea[5:2]];
    case (sz)
      0: begin v = 32'(w[8*off +: 8]); if (!f3[2]) v = {{24{v[7]}}, v[7:0]}; t = "R8 byte read"; end
      1: begin v = 32'(w[16*ea[1] +: 16]); if (!f3[2]) v = {{16{v[15]}}, v[15:0]}; t = "R9 half read"; end
      default: begin v = w; t = (f3 == 3'b010) ? "R10 word read" : "R2 alt word code"; end
    endcase
    @(posedge clk_i);
    if (acc && we)
      for (int b = 0; b < 4; b++) if (exp_be[b]) exp_mem[ea[5:2]][8*b +: 8] = exp_wd[8*b +: 8];
    pend_v = acc && !we; pend_d = v; pend_tag = t;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [2:0] codes [8] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd3, 3'd6, 3'd7};
    for (int i = 0; i < 16; i++) begin
      mem[i] = (32'(i) * 32'h1357_9BDF) ^ 32'h80F0_7F81;
      exp_mem[i] = mem[i];
    end
    repeat (2) @(posedge clk_i);
    #3;
    chk("R12 load_valid_o in reset", 32'(load_valid_o), 0);
    chk("R11 mem_req_o in reset", 32'(mem_req_o), 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    // byte stores, every lane
    for (int o = 0; o < 4; o++) step(1, 1, 3'd0, 32'h10, 32'(o), 32'hA5C3_E100 + 32'(o));
    // half and word stores, aligned and not
    for (int o = 0; o < 4; o++) step(1, 1, 3'd1, 32'h20, 32'(o), 32'h1234_F00D);
    for (int o = 0; o < 4; o++) step(1, 1, 3'd2, 32'h30, 32'(o), 32'hDEAD_BEEF);
    // reads of all kinds over lanes, negative offset
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 4; o++) step(1, 0, codes[c], 32'h44, 32'(o) - 32'h4, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 3'd0, 32'h11, 0, 0);
    step(1, 0, 3'd4, 32'h11, 0, 0);
    step(1, 0, 3'd1, 32'h22, 0, 0);
    step(1, 0, 3'd5, 32'h22, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], codes[r[5:3]], $urandom, (r[6] ? $urandom : 32'(r[11:7])), $urandom);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule